// File: doc/BRIEF.md
# Edge-Triggered Event Line Controller

This block watches a set of asynchronous input lines (16 by default) and turns selected transitions on them into interrupts, single-cycle event strobes and wakeup requests. Each line is first brought into the bus clock domain. Its rising and falling transitions are then detected and qualified by per-line enable and mask registers. Software can also fire a line directly, and this behaves like a rising transition.

Interrupts are held in two pending flags per line, one for rising and one for falling triggers. A line's interrupt output stays high while either of its flags is set. Software acknowledges a flag by writing 1 to it. The event path keeps no state and produces only a one-cycle strobe. All registers sit on a simple word-addressed interface clocked by the same clock. Writes take effect on the clock edge, and reads are combinational.

Top module: `evtline_ctrl`

## Requirements
- R1: A hardware transition on a line passes through two synchronizer flops and one edge-history flop. An enabled, unmasked rising transition that is driven before clock edge A becomes visible on `irq` and in the rising pending register just after edge A+2, and not earlier.
- R2: Each line has its own rising enable (offset 0x00, bit n) and falling enable (offset 0x04, bit n). With both enables set, either transition triggers the line. A rising trigger sets only the rising pending flag (offset 0x0C, bit n), and a falling trigger sets only the falling pending flag (offset 0x10, bit n).
- R3: Writing 1 to bit n at offset 0x08 triggers line n as a rising transition one clock after the write. It sets rising pending bit n even when both edge enables of that line are 0. Offset 0x08 always reads as 0.
- R4: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a set and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: A pending flag is set only when interrupt mask bit n (offset 0x80) is 1. `irq[n]` is high exactly while rising or falling pending bit n is set.
- R6: When event mask bit n (offset 0x84) is 1, a trigger produces a `evt_strobe[n]` pulse lasting exactly one cycle, in the same cycle the pending flag would become visible. No state is kept for events.
- R7: `wake_req[n]` pulses for one cycle on a trigger of line n when interrupt mask bit n or event mask bit n is 1. It stays low when both are 0.
- R8: A hardware rising (falling) transition that is being qualified in the same cycle as a write to the rising (falling) enable register is dropped. It produces no pending flag, no strobe and no wakeup.
- R9: After reset, every register reads 0 and all outputs are low. Bits above the line count and unmapped offsets read as 0.
- R10: A transition whose edge enable is 0 has no effect on the pending flags or on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | NUM_LINES | Asynchronous event lines |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | NUM_LINES | Per-line interrupt, high while a pending flag is set |
| evt_strobe | output | NUM_LINES | Per-line one-cycle event pulse |
| wake_req | output | NUM_LINES | Per-line one-cycle wakeup pulse |

## Verification
The assertions assume that each input line holds a new level for at least two clocks, so that the synchronizer sees each transition exactly once. They also assume that writes are single-cycle strobes with a stable address. The bench changes lines and bus signals only on the falling clock edge. It holds every level for several cycles, and it keeps each write to one clock, which keeps the stimulus inside these assumptions. The one deliberate overlap is the case where a write coincides with an edge being qualified. The bench times this to the exact cycle in which the detected edge is present.

// File: rtl/evl_pkg.sv
// Package: shared offsets and widths of the event line controller.
// Assumes byte offsets on an 8-bit address and 32-bit data words.
package evl_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_RISE_EN = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_FALL_EN = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_SWTRIG  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PEND_R  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_PEND_F  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_IRQ_MSK = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_EVT_MSK = 8'h84;
endpackage

// File: rtl/evl_sync_edge.sv
// Module: per-line synchronizer and edge detector.
// Each line passes through SYNC_STAGES flops, then one history flop.
// The rise and fall outputs are combinational from these flops and last one cycle.
// Assumes each input level is held for at least two clocks.
module evl_sync_edge #(
    parameter int NUM_LINES   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] rise,
    output logic [NUM_LINES-1:0] fall
);
    localparam int LAST = SYNC_STAGES - 1;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] sync_q;
        logic                   hist_q;

        // Shift the raw line into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q <= '0;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], line_in[g]};
            end
        end

        // Remember the previous synchronized level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist_q <= 1'b0;
            end else begin
                hist_q <= sync_q[LAST];
            end
        end

        // Compare the current and previous levels.
        always_comb begin
            rise[g] = sync_q[LAST] & ~hist_q;
            fall[g] = ~sync_q[LAST] & hist_q;
        end
    end
endmodule

// File: rtl/evl_regs.sv
// Module: register file of the event line controller.
// It holds the edge enables, the masks, a self-clearing software trigger and the
// rising/falling pending flags. A set of a pending flag wins over a write-1 clear.
// Reads are combinational. Bits above NUM_LINES and unmapped offsets read as 0.
module evl_regs
    import evl_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wen,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] set_r,
    input  logic [NUM_LINES-1:0] set_f,
    output logic [NUM_LINES-1:0] rise_en,
    output logic [NUM_LINES-1:0] fall_en,
    output logic [NUM_LINES-1:0] irq_msk,
    output logic [NUM_LINES-1:0] evt_msk,
    output logic [NUM_LINES-1:0] sw_pulse,
    output logic [NUM_LINES-1:0] pend_r,
    output logic [NUM_LINES-1:0] pend_f,
    output logic                 rise_en_wr,
    output logic                 fall_en_wr
);
    logic [NUM_LINES-1:0] wbits;
    logic [NUM_LINES-1:0] clr_r;
    logic [NUM_LINES-1:0] clr_f;
    logic                 unused_wdata_hi;

    // Decode the write strobes and the clear masks.
    always_comb begin
        wbits           = reg_wdata[NUM_LINES-1:0];
        unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_LINES];
        rise_en_wr      = reg_wen && (reg_addr == OFS_RISE_EN);
        fall_en_wr      = reg_wen && (reg_addr == OFS_FALL_EN);
        clr_r           = (reg_wen && (reg_addr == OFS_PEND_R)) ? wbits : '0;
        clr_f           = (reg_wen && (reg_addr == OFS_PEND_F)) ? wbits : '0;
    end

    // Hold the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
            irq_msk <= '0;
            evt_msk <= '0;
        end else if (reg_wen) begin
            case (reg_addr)
                OFS_RISE_EN: rise_en <= wbits;
                OFS_FALL_EN: fall_en <= wbits;
                OFS_IRQ_MSK: irq_msk <= wbits;
                OFS_EVT_MSK: evt_msk <= wbits;
                default:     ;
            endcase
        end
    end

    // The software trigger lives for one cycle after its write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_pulse <= '0;
        end else begin
            sw_pulse <= (reg_wen && (reg_addr == OFS_SWTRIG)) ? wbits : '0;
        end
    end

    // Update the pending flags; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_r <= '0;
            pend_f <= '0;
        end else begin
            pend_r <= (pend_r & ~clr_r) | set_r;
            pend_f <= (pend_f & ~clr_f) | set_f;
        end
    end

    // Select the read data; the software trigger reads as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_RISE_EN: reg_rdata[NUM_LINES-1:0] = rise_en;
            OFS_FALL_EN: reg_rdata[NUM_LINES-1:0] = fall_en;
            OFS_PEND_R:  reg_rdata[NUM_LINES-1:0] = pend_r;
            OFS_PEND_F:  reg_rdata[NUM_LINES-1:0] = pend_f;
            OFS_IRQ_MSK: reg_rdata[NUM_LINES-1:0] = irq_msk;
            OFS_EVT_MSK: reg_rdata[NUM_LINES-1:0] = evt_msk;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evl_trigger.sv
// Module: trigger qualification and the registered event/wakeup pulses.
// A hardware edge counts when its enable is set and no write to that enable
// register happens in the same cycle. The software pulse acts as a rising edge.
// The pending sets are combinational; the strobe and wakeup outputs are flops.
module evl_trigger #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] hw_rise,
    input  logic [NUM_LINES-1:0] hw_fall,
    input  logic [NUM_LINES-1:0] sw_pulse,
    input  logic [NUM_LINES-1:0] rise_en,
    input  logic [NUM_LINES-1:0] fall_en,
    input  logic [NUM_LINES-1:0] irq_msk,
    input  logic [NUM_LINES-1:0] evt_msk,
    input  logic                 rise_en_wr,
    input  logic                 fall_en_wr,
    output logic [NUM_LINES-1:0] set_r,
    output logic [NUM_LINES-1:0] set_f,
    output logic [NUM_LINES-1:0] evt_q,
    output logic [NUM_LINES-1:0] wake_q
);
    logic [NUM_LINES-1:0] trig_r;
    logic [NUM_LINES-1:0] trig_f;
    logic [NUM_LINES-1:0] trig_any;

    // Qualify the edges and derive the pending-flag sets.
    always_comb begin
        trig_r   = (hw_rise & rise_en & ~{NUM_LINES{rise_en_wr}}) | sw_pulse;
        trig_f   = hw_fall & fall_en & ~{NUM_LINES{fall_en_wr}};
        trig_any = trig_r | trig_f;
        set_r    = trig_r & irq_msk;
        set_f    = trig_f & irq_msk;
    end

    // Register the one-cycle event and wakeup pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q  <= '0;
            wake_q <= '0;
        end else begin
            evt_q  <= trig_any & evt_msk;
            wake_q <= trig_any & (irq_msk | evt_msk);
        end
    end
endmodule

// File: rtl/evtline_ctrl.sv
// Module: top of the edge-triggered event line controller.
// It chains the synchronizer/edge stage, the trigger qualification and the
// register file. The interrupt of a line is the OR of its two pending flags.
// Assumes one clock domain for the bus and the logic, with a synchronous active-low reset.
module evtline_ctrl
    import evl_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 reg_wen,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_LINES-1:0] irq,
    output logic [NUM_LINES-1:0] evt_strobe,
    output logic [NUM_LINES-1:0] wake_req
);
    logic [NUM_LINES-1:0] hw_rise;
    logic [NUM_LINES-1:0] hw_fall;
    logic [NUM_LINES-1:0] set_r;
    logic [NUM_LINES-1:0] set_f;
    logic [NUM_LINES-1:0] rise_en;
    logic [NUM_LINES-1:0] fall_en;
    logic [NUM_LINES-1:0] irq_msk;
    logic [NUM_LINES-1:0] evt_msk;
    logic [NUM_LINES-1:0] sw_pulse;
    logic [NUM_LINES-1:0] pend_r;
    logic [NUM_LINES-1:0] pend_f;
    logic                 rise_en_wr;
    logic                 fall_en_wr;

    evl_sync_edge #(
        .NUM_LINES  (NUM_LINES),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .rise   (hw_rise),
        .fall   (hw_fall)
    );

    evl_trigger #(
        .NUM_LINES(NUM_LINES)
    ) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_rise   (hw_rise),
        .hw_fall   (hw_fall),
        .sw_pulse  (sw_pulse),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .irq_msk   (irq_msk),
        .evt_msk   (evt_msk),
        .rise_en_wr(rise_en_wr),
        .fall_en_wr(fall_en_wr),
        .set_r     (set_r),
        .set_f     (set_f),
        .evt_q     (evt_strobe),
        .wake_q    (wake_req)
    );

    evl_regs #(
        .NUM_LINES(NUM_LINES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .set_r     (set_r),
        .set_f     (set_f),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .irq_msk   (irq_msk),
        .evt_msk   (evt_msk),
        .sw_pulse  (sw_pulse),
        .pend_r    (pend_r),
        .pend_f    (pend_f),
        .rise_en_wr(rise_en_wr),
        .fall_en_wr(fall_en_wr)
    );

    // Drive each line's interrupt from its pending flags.
    always_comb begin
        irq = pend_r | pend_f;
    end
endmodule

// File: rtl/evtline_ctrl_chk.sv
// Module: property checker bound to the event line controller.
// It observes the pending flags, masks, sets and bus writes and checks how they relate over time.
module evtline_ctrl_chk
    import evl_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wen,
    input logic [7:0]           reg_addr,
    input logic [31:0]          reg_wdata,
    input logic [31:0]          reg_rdata,
    input logic [NUM_LINES-1:0] pend_r,
    input logic [NUM_LINES-1:0] pend_f,
    input logic [NUM_LINES-1:0] set_r,
    input logic [NUM_LINES-1:0] irq_msk,
    input logic [NUM_LINES-1:0] evt_msk,
    input logic [NUM_LINES-1:0] irq,
    input logic [NUM_LINES-1:0] evt_strobe,
    input logic [NUM_LINES-1:0] wake_req
);
    logic [NUM_LINES-1:0] clr_only;
    logic                 unused_chk_hi;

    // Form the rising-flag clears that are not overridden by a set.
    always_comb begin
        clr_only      = (reg_wen && (reg_addr == OFS_PEND_R)) ? (reg_wdata[NUM_LINES-1:0] & ~set_r) : '0;
        unused_chk_hi = ^reg_wdata[31:NUM_LINES];
    end

    assert_pend_needs_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend_r & ~$past(pend_r)) | (pend_f & ~$past(pend_f))) & ~$past(irq_msk)) == '0);

    assert_irq_follows_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_r | pend_f) == '0) |-> (irq == '0));

    assert_evt_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_strobe & ~$past(evt_msk)) == '0);

    assert_wake_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req & ~$past(irq_msk | evt_msk)) == '0);

    assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_only != '0) |=> ((pend_r & $past(clr_only)) == '0));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_r != '0) |=> ((pend_r & $past(set_r)) == $past(set_r)));

    assert_swtrig_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_SWTRIG) |-> (reg_rdata == '0));
endmodule

bind evtline_ctrl evtline_ctrl_chk #(
    .NUM_LINES(NUM_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pend_r    (pend_r),
    .pend_f    (pend_f),
    .set_r     (set_r),
    .irq_msk   (irq_msk),
    .evt_msk   (evt_msk),
    .irq       (irq),
    .evt_strobe(evt_strobe),
    .wake_req  (wake_req)
);

// File: tb/evtline_ctrl_test.sv
// Bench: directed scenarios for the event line controller, one task each.
// Inputs change on falling edges; outputs are sampled at falling edges.
module evtline_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  line_in = '0;
    logic          reg_wen = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  irq;
    logic [N-1:0]  evt_strobe;
    logic [N-1:0]  wake_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evtline_ctrl #(.NUM_LINES(N), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .evt_strobe(evt_strobe), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-clock write; starts and ends at a falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wen = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clean();
        wr(8'h0C, 32'hFFFF); wr(8'h10, 32'hFFFF);
        wr(8'h00, 0); wr(8'h04, 0); wr(8'h80, 0); wr(8'h84, 0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); chk("R9 rise enable reset", d, 0);
        rd(8'h0C, d); chk("R9 rising pending reset", d, 0);
        rd(8'h80, d); chk("R9 irq mask reset", d, 0);
        rd(8'h84, d); chk("R9 event mask reset", d, 0);
        chk("R9 outputs reset", {irq, evt_strobe}, 0);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R9 unused bits read 0", d, 32'h0000_FFFF);
        rd(8'h40, d); chk("R9 unmapped offset", d, 0);
        wr(8'h00, 0);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        wr(8'h00, 32'h1); wr(8'h80, 32'h1);
        line_in[0] = 1'b1;
        cycles(2); chk("R1 not visible after two clocks", irq, 0);
        cycles(1); chk("R1 irq after three clocks", irq, 16'h0001);
        rd(8'h0C, d); chk("R1 rising pending", d, 1);
        wr(8'h0C, 32'h0); rd(8'h0C, d); chk("R4 write 0 no effect", d, 1);
        wr(8'h0C, 32'h1); rd(8'h0C, d); chk("R4 write 1 clears", d, 0);
        chk("R4 irq drops", irq, 0);
        line_in[0] = 1'b0;
        cycles(4); rd(8'h10, d); chk("R10 disabled fall ignored", d, 0);
        chk("R10 irq stays low", irq, 0);
        clean();
    endtask

    task automatic t_both();
        logic [31:0] d;
        wr(8'h00, 32'h8); wr(8'h04, 32'h8); wr(8'h80, 32'h8);
        line_in[3] = 1'b1; cycles(3);
        rd(8'h0C, d); chk("R2 rise sets rising flag", d, 32'h8);
        rd(8'h10, d); chk("R2 rise leaves falling flag", d, 0);
        wr(8'h0C, 32'h8);
        line_in[3] = 1'b0; cycles(3);
        rd(8'h10, d); chk("R2 fall sets falling flag", d, 32'h8);
        rd(8'h0C, d); chk("R2 fall leaves rising flag", d, 0);
        chk("R5 irq from falling flag", irq, 16'h0008);
        clean();
    endtask

    task automatic t_sw();
        logic [31:0] d;
        wr(8'h80, 32'h20); wr(8'h84, 32'h20);
        wr(8'h08, 32'h20);
        rd(8'h08, d); chk("R3 trigger reads 0", d, 0);
        cycles(1);
        rd(8'h0C, d); chk("R3 rising pending without enables", d, 32'h20);
        chk("R6 strobe from software trigger", evt_strobe, 16'h0020);
        cycles(1); chk("R3 single trigger only", evt_strobe, 0);
        wr(8'h0C, 32'h20);
        wr(8'h08, 32'h20);
        wr(8'h0C, 32'h20);
        rd(8'h0C, d); chk("R4 set wins over clear", d, 32'h20);
        clean();
    endtask

    task automatic t_mask();
        logic [N-1:0] wacc = '0;
        logic [31:0] d;
        wr(8'h00, 32'h80);
        line_in[7] = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); wacc |= wake_req;
        end
        rd(8'h0C, d); chk("R5 masked line no pending", d, 0);
        chk("R5 masked line no irq", irq, 0);
        chk("R7 no wake with both masks 0", wacc, 0);
        line_in[7] = 1'b0; cycles(4);
        clean();
    endtask

    task automatic t_event();
        logic [31:0] d;
        wr(8'h00, 32'h100); wr(8'h84, 32'h100);
        line_in[8] = 1'b1; cycles(3);
        chk("R6 strobe on edge", evt_strobe, 16'h0100);
        chk("R7 wake with event mask", wake_req, 16'h0100);
        cycles(1);
        chk("R6 strobe lasts one cycle", evt_strobe, 0);
        chk("R7 wake lasts one cycle", wake_req, 0);
        rd(8'h0C, d); chk("R6 no pending kept", d, 0);
        wr(8'h84, 0); wr(8'h80, 32'h100);
        line_in[8] = 1'b0; cycles(4);
        line_in[8] = 1'b1; cycles(3);
        chk("R7 wake with irq mask", wake_req, 16'h0100);
        chk("R6 no strobe when event masked", evt_strobe, 0);
        line_in[8] = 1'b0; cycles(2);
        clean();
    endtask

    task automatic t_collide();
        logic [31:0] d;
        wr(8'h00, 32'h400); wr(8'h80, 32'h400);
        line_in[10] = 1'b1;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        wr(8'h00, 32'h400);
        cycles(2);
        rd(8'h0C, d); chk("R8 edge during enable write dropped", d, 0);
        chk("R8 no irq", irq, 0);
        line_in[10] = 1'b0; cycles(4);
        line_in[10] = 1'b1; cycles(3);
        rd(8'h0C, d); chk("R8 later edge counts", d, 32'h400);
        line_in[10] = 1'b0; cycles(2);
        clean();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_rise();
        t_both();
        t_sw();
        t_mask();
        t_event();
        t_collide();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule